// File: doc/BRIEF.md
# Byte-to-Word DMA Staging Buffer

This block sits between a byte-wide peripheral DMA channel and a 32-bit local bus. Each incoming byte is taken with a request/acknowledge handshake. Bytes are packed big-endian into a 32-byte main buffer. Only when that buffer is completely full does the block ask for the bus. It then writes the buffer out as a burst of eight 32-bit words to consecutive addresses.

While a burst is being arranged and written, an 8-byte secondary FIFO keeps accepting peripheral bytes, so the byte stream need not pause. Once the burst ends, the bytes held in the secondary FIFO move into the main buffer, one per cycle, ahead of any newer byte. Stream order is therefore kept.

Software-side logic starts a job by pulsing `start` with a byte count and a destination address. When the count is used up, a partly filled main buffer is flushed in a shorter burst, and byte enables mark the valid lanes of the last word. `done` rises once every byte of the job has been written.

Top module: `byte_word_stager`

## Requirements
- R1: `in_ack` is never high before the first `start`, and it is never high once the loaded byte count has been accepted. The number of bytes taken (cycles with `in_req` and `in_ack` both high) equals `start_count` exactly.
- R2: Packing is big-endian: the earliest byte of each group of four appears on `wr_data[31:24]`, the next on `[23:16]`, then `[15:8]`, then `[7:0]`.
- R3: `bus_req` rises only when the main buffer holds all 32 bytes, or when the byte count is exhausted and the secondary FIFO is empty (terminal flush).
- R4: `bus_own` rises only after `bus_grant` has been seen while `bus_req` was high. `bus_req` stays high until it is granted and is low whenever `bus_own` is high. `wr_valid` is high only while `bus_own` is high. All three are low after reset.
- R5: A burst from a full main buffer is exactly 8 write cycles. A flush burst holds ceil(remaining bytes / 4) words.
- R6: The first word of a job is written to `start_addr`, and each later word of the job is written to the previous address plus 4.
- R7: Bytes reach the bus in the order they were accepted, including bytes that passed through the secondary FIFO.
- R8: While a burst is pending, `in_ack` stays available until the secondary FIFO holds 8 bytes. With the grant withheld and bytes offered every cycle, exactly 40 bytes are taken before the stall.
- R9: With one byte offered every second cycle and a grant given in the cycle `bus_req` is seen, `in_ack` is never withheld from a pending byte.
- R10: `wr_be[3]` enables lane `[31:24]` and `wr_be[0]` enables lane `[7:0]`. Every word is 4'b1111, except the last word of a job that holds k < 4 bytes: that word carries the top k bits set (1: 4'b1000, 2: 4'b1100, 3: 4'b1110).
- R11: `done` is low after reset. It is high once all bytes of a started job have been written and both buffers are empty, and it drops after a new `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that loads byte count and destination address |
| start_count | input | 24 | Number of bytes in the job |
| start_addr | input | 32 | Address of the first word |
| in_req | input | 1 | Peripheral offers a byte |
| in_data | input | 8 | Offered byte |
| in_ack | output | 1 | Byte taken in this cycle |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Bus grant from the arbiter |
| bus_own | output | 1 | Grant acknowledge, held for the whole burst |
| wr_valid | output | 1 | Word write strobe |
| wr_addr | output | 32 | Word write address |
| wr_data | output | 32 | Word write data |
| wr_be | output | 4 | Byte lane enables |
| done | output | 1 | Job completely written |

## Verification
Jobs of exactly one full buffer and of two full buffers show the gating and length of full bursts. Short and odd counts (3, 6, 37) expose the flush path and each byte-enable pattern. A steady half-rate stream with immediate grant separates a design that can absorb input during a burst from one that stalls. A withheld grant with input offered every cycle pins the combined capacity at 40 bytes. Random counts, offer densities and grant latencies then mix secondary-to-main transfers with new arrivals, which would reveal any reordering.

// File: rtl/stg_pkg.sv
package stg_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_OWN, ST_END} burst_st_e;
endpackage

// File: rtl/stg_sec_fifo.sv
module stg_sec_fifo #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        push,
  input  logic [7:0]  din,
  input  logic        pop,
  output logic [7:0]  dout,
  output logic [AW:0] count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign dout = mem[rptr];
endmodule

// File: rtl/stg_main_buf.sv
module stg_main_buf #(
  parameter int BYTES = 32,
  localparam int BW  = $clog2(BYTES),
  localparam int FW  = BW + 1,
  localparam int WIW = BW - 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [7:0]     wdata,
  input  logic           clr,
  input  logic [WIW-1:0] rd_idx,
  output logic [31:0]    rd_word,
  output logic [FW-1:0]  fill
);
  logic [7:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (wr) mem[fill[BW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) fill <= '0;
    else if (wr)    fill <= fill + 1'b1;
  end

  // big-endian lanes: byte 4*i lands in bits 31:24
  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign rd_word[31-8*l -: 8] = mem[{rd_idx, 2'(l)}];
  end
endmodule

// File: rtl/stg_burst_ctl.sv
module stg_burst_ctl import stg_pkg::*; #(
  parameter int MAIN_BYTES = 32,
  parameter int CNT_W      = 24,
  parameter int ADDR_W     = 32,
  localparam int BW  = $clog2(MAIN_BYTES),
  localparam int FW  = BW + 1,
  localparam int WIW = BW - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  start_count,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              take,
  input  logic [FW-1:0]     fill,
  input  logic              sec_empty,
  input  logic              bus_grant,
  input  logic [31:0]       rd_word,
  output logic              idle,
  output logic              rem_zero,
  output logic [WIW-1:0]    rd_idx,
  output logic              main_clr,
  output logic              bus_req,
  output logic              bus_own,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_be,
  output logic              done
);
  burst_st_e         state;
  logic [CNT_W-1:0]  rem;
  logic [ADDR_W-1:0] addr;
  logic              started;
  logic [WIW:0]      wcnt, nwords;
  logic [1:0]        tail;
  logic              last;

  assign idle     = (state == ST_IDLE);
  assign rem_zero = (rem == '0);
  assign rd_idx   = wcnt[WIW-1:0];
  assign main_clr = (state == ST_END);
  assign last     = (wcnt == nwords - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      rem      <= '0;
      addr     <= '0;
      started  <= 1'b0;
      bus_req  <= 1'b0;
      bus_own  <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_be    <= '0;
      wcnt     <= '0;
      nwords   <= '0;
      tail     <= '0;
      done     <= 1'b0;
    end else begin
      done <= started && rem_zero && sec_empty && (fill == '0) && idle;
      if (start) begin
        rem     <= start_count;
        addr    <= start_addr;
        started <= 1'b1;
      end else if (take) begin
        rem <= rem - 1'b1;
      end
      case (state)
        ST_IDLE: begin
          if (fill == FW'(MAIN_BYTES) || (rem_zero && sec_empty && fill != '0)) begin
            bus_req <= 1'b1;
            nwords  <= fill[FW-1:2] + {{WIW{1'b0}}, |fill[1:0]};
            tail    <= fill[1:0];
            state   <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (bus_grant) begin
            bus_req <= 1'b0;
            bus_own <= 1'b1;
            wcnt    <= '0;
            state   <= ST_OWN;
          end
        end
        ST_OWN: begin
          wr_valid <= 1'b1;
          wr_data  <= rd_word;
          wr_addr  <= addr;
          addr     <= addr + ADDR_W'(4);
          wr_be    <= (last && tail != 2'd0) ? ~(4'hF >> tail) : 4'hF;
          wcnt     <= wcnt + 1'b1;
          if (last) state <= ST_END;
        end
        default: begin
          wr_valid <= 1'b0;
          bus_own  <= 1'b0;
          state    <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/byte_word_stager.sv
module byte_word_stager #(
  parameter int MAIN_BYTES = 32,
  parameter int SEC_BYTES  = 8,
  parameter int CNT_W      = 24,
  parameter int ADDR_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  start_count,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              in_req,
  input  logic [7:0]        in_data,
  output logic              in_ack,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              bus_own,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_be,
  output logic              done
);
  localparam int BW  = $clog2(MAIN_BYTES);
  localparam int FW  = BW + 1;
  localparam int WIW = BW - 2;
  localparam int SAW = $clog2(SEC_BYTES);

  logic [FW-1:0]  main_fill;
  logic [SAW:0]   sec_cnt;
  logic [7:0]     sec_rdata, main_wdata;
  logic [WIW-1:0] rd_idx;
  logic [31:0]    rd_word;
  logic idle, rem_zero, main_clr;
  logic sec_empty, main_room, to_main, accept, move, main_wr, sec_push;

  assign sec_empty = (sec_cnt == '0);
  assign main_room = (main_fill < FW'(MAIN_BYTES));
  // new bytes go straight to main only when nothing older is waiting
  assign to_main   = idle && sec_empty && main_room;
  assign accept    = !rem_zero && (to_main || sec_cnt < (SAW+1)'(SEC_BYTES));
  assign in_ack    = in_req && accept;
  assign move      = idle && !sec_empty && main_room;
  assign main_wr   = (in_ack && to_main) || move;
  assign main_wdata = move ? sec_rdata : in_data;
  assign sec_push  = in_ack && !to_main;

  stg_sec_fifo #(.DEPTH(SEC_BYTES)) u_sec (
    .clk(clk), .rst(rst), .push(sec_push), .din(in_data),
    .pop(move), .dout(sec_rdata), .count(sec_cnt)
  );

  stg_main_buf #(.BYTES(MAIN_BYTES)) u_main (
    .clk(clk), .rst(rst), .wr(main_wr), .wdata(main_wdata), .clr(main_clr),
    .rd_idx(rd_idx), .rd_word(rd_word), .fill(main_fill)
  );

  stg_burst_ctl #(.MAIN_BYTES(MAIN_BYTES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst(rst), .start(start), .start_count(start_count),
    .start_addr(start_addr), .take(in_ack), .fill(main_fill),
    .sec_empty(sec_empty), .bus_grant(bus_grant), .rd_word(rd_word),
    .idle(idle), .rem_zero(rem_zero), .rd_idx(rd_idx), .main_clr(main_clr),
    .bus_req(bus_req), .bus_own(bus_own), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .done(done)
  );
endmodule

// File: rtl/stg_checker.sv
module stg_checker #(
  parameter int MAIN_BYTES = 32,
  parameter int SEC_BYTES  = 8,
  parameter int ADDR_W     = 32,
  localparam int FW  = $clog2(MAIN_BYTES) + 1,
  localparam int SAW = $clog2(SEC_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_grant,
  input logic              bus_own,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [FW-1:0]     main_fill,
  input logic              rem_zero,
  input logic [SAW:0]      sec_cnt
);
  p_req_full_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> ($past(main_fill) == FW'(MAIN_BYTES)) || $past(rem_zero));

  p_main_bound_r3: assert property (@(posedge clk) disable iff (rst)
    main_fill <= FW'(MAIN_BYTES));

  p_own_after_grant_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_own) |-> $past(bus_grant) && $past(bus_req));

  p_req_held_r4: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_grant |=> bus_req);

  p_req_own_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_own));

  p_write_owned_r4: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> bus_own);

  p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
    wr_valid && $past(wr_valid) |-> wr_addr == $past(wr_addr) + ADDR_W'(4));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    sec_cnt <= (SAW+1)'(SEC_BYTES));
endmodule

bind byte_word_stager stg_checker #(
  .MAIN_BYTES(MAIN_BYTES), .SEC_BYTES(SEC_BYTES), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_grant(bus_grant),
  .bus_own(bus_own), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .main_fill(main_fill), .rem_zero(rem_zero), .sec_cnt(sec_cnt)
);

// File: tb/byte_word_stager_bench.sv
module byte_word_stager_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_N      = 256;

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [23:0] start_count = '0;
  logic [31:0] start_addr = '0;
  logic        in_req = 1'b0, bus_grant = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ack, bus_req, bus_own, wr_valid, done;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_be;

  int errors = 0, checks = 0;
  int taken = 0, words_seen = 0, cur_n = 0, stalls = 0;
  int burst_writes = 0, burst_base = 0, grant_lat = 0;
  bit grant_hold = 1'b0, prev_req = 1'b0, prev_own = 1'b0, running = 1'b1;
  logic [31:0] base_addr = '0;
  logic [7:0]  exp_bytes [MAX_N];

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_word_stager u_byte_word_stager (
    .clk(clk), .rst(rst), .start(start), .start_count(start_count),
    .start_addr(start_addr), .in_req(in_req), .in_data(in_data),
    .in_ack(in_ack), .bus_req(bus_req), .bus_grant(bus_grant),
    .bus_own(bus_own), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int idx);
    logic [31:0] w = '0;
    for (int l = 0; l < 4; l++)
      if (4*idx + l < cur_n) w[31-8*l -: 8] = exp_bytes[4*idx + l];
    return w;
  endfunction

  function automatic logic [3:0] exp_be(input int idx);
    int valid = cur_n - 4*idx;
    if (valid >= 4) return 4'hF;
    return ~(4'hF >> valid);
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  // arbiter model
  initial begin
    forever begin
      @(negedge clk);
      if (bus_req && !bus_grant) begin
        repeat (grant_lat) @(negedge clk);
        while (grant_hold) @(negedge clk);
        bus_grant = 1'b1;
        do @(negedge clk); while (!bus_own);
        bus_grant = 1'b0;
      end
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (!rst && running) begin
      int pend, total, expb;
      total = (cur_n + 3) / 4;
      if (bus_own && !prev_own) begin
        burst_base   = words_seen;
        burst_writes = 0;
      end
      if (wr_valid) begin
        check(wr_be == exp_be(words_seen), "R10", "byte enables", {28'd0, wr_be},
              {28'd0, exp_be(words_seen)});
        check((wr_data & lane_mask(wr_be)) == (exp_word(words_seen) & lane_mask(wr_be)),
              "R2 R7", "packed word", wr_data & lane_mask(wr_be),
              exp_word(words_seen) & lane_mask(wr_be));
        check(wr_addr == base_addr + 32'(4*words_seen), "R6", "write address",
              wr_addr, base_addr + 32'(4*words_seen));
        words_seen++;
        burst_writes++;
      end
      if (bus_req && !prev_req) begin
        pend = taken - 4*words_seen;
        check(pend >= 32 || taken == cur_n, "R3", "bytes buffered at request",
              32'(pend), 32'd32);
      end
      if (!bus_own && prev_own) begin
        expb = (total - burst_base < 8) ? total - burst_base : 8;
        check(burst_writes == expb, "R5", "burst length", 32'(burst_writes), 32'(expb));
      end
      prev_req = bus_req;
      prev_own = bus_own;
    end
  end

  task automatic send(input int n, input int period, input int pct);
    int cyc = 0;
    while (taken < n) begin
      bit offer;
      @(negedge clk);
      offer = (cyc % period == 0) && (($urandom % 100) < pct);
      in_req  = offer;
      in_data = exp_bytes[taken];
      #1;
      if (offer) begin
        if (in_ack) taken++;
        else stalls++;
      end
      cyc++;
    end
    @(negedge clk);
    in_req = 1'b0;
  endtask

  task automatic run(input int n, input logic [31:0] addr, input int period,
                     input int pct, input int lat, input bit gapfree, input bit hold);
    int t = 0;
    cur_n = n; taken = 0; words_seen = 0; stalls = 0;
    grant_lat = lat; base_addr = addr;
    for (int i = 0; i < n; i++) exp_bytes[i] = 8'($urandom);
    @(negedge clk);
    start = 1'b1; start_count = 24'(n); start_addr = addr;
    @(negedge clk);
    start = 1'b0;
    if (hold) begin
      grant_hold = 1'b1;
      fork
        send(n, period, pct);
        begin
          repeat (80) @(negedge clk);
          check(taken == 40, "R8", "bytes taken with grant withheld", 32'(taken), 32'd40);
          check(bus_own == 1'b0, "R4", "no ownership without grant", {31'd0, bus_own}, 32'd0);
          grant_hold = 1'b0;
        end
      join
    end else begin
      send(n, period, pct);
    end
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check(done == 1'b1, "R11", "done after job", {31'd0, done}, 32'd1);
    check(words_seen == (n + 3) / 4, "R7", "words written", 32'(words_seen), 32'((n + 3) / 4));
    if (gapfree) check(stalls == 0, "R9", "stalled offers", 32'(stalls), 32'd0);
    @(negedge clk);
    in_req = 1'b1;
    #1;
    check(in_ack == 1'b0, "R1", "ack after count used", {31'd0, in_ack}, 32'd0);
    @(negedge clk);
    in_req = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    in_req = 1'b1;
    #1;
    check(in_ack == 1'b0, "R1", "ack before start", {31'd0, in_ack}, 32'd0);
    check({bus_req, bus_own, wr_valid} == 3'b000, "R4", "bus outputs after reset",
          {29'd0, bus_req, bus_own, wr_valid}, 32'd0);
    check(done == 1'b0, "R11", "done after reset", {31'd0, done}, 32'd0);
    @(negedge clk);
    in_req = 1'b0;

    run(32, 32'h0000_1000, 1, 100, 2, 1'b0, 1'b0);
    run(64, 32'h0000_2000, 2, 100, 0, 1'b1, 1'b0);
    run(64, 32'h0000_3000, 1, 100, 0, 1'b0, 1'b1);
    run(37, 32'h0000_4000, 1, 100, 1, 1'b0, 1'b0);
    run(3,  32'h0000_5000, 1, 100, 1, 1'b0, 1'b0);
    run(6,  32'h0000_6000, 1, 100, 3, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++)
      run(1 + int'($urandom % 120), 32'h0001_0000 + 32'(k) * 32'h400, 1,
          30 + int'($urandom % 71), int'($urandom % 4), 1'b0, 1'b0);

    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule